// File: doc/BRIEF.md
# Target Read Transfer Sequencer

This block is the control state machine for a read aimed at a bus target. It sits between the bus-side handshake (target selected, master finishing, data-ready, stop) and the application side of the target read FIFO. It decides when the target starts to signal data-ready on the bus. It lets the application prefill the FIFO under a hold input. It tells the application when a transaction is open, when the master has taken its last word, and when the FIFO is being flushed.

After selection the sequencer parks in a hold phase and keeps data-ready low. The application keeps writing into the FIFO during this phase. The bus data phase starts once the hold is released or the FIFO reports full. Data phases then run back to back while the FIFO holds data. An empty FIFO causes a disconnect. A read also ends when the master finishes, or when the target answers with a retry because another target transaction is pending.

If the read ends while the application is not driving data-enable, the sequencer drops its ready output and flushes the FIFO. It issues the last-cycle indication only once data-enable returns. The request output then falls for at least one clock, so the application can tell the next transaction apart from this one. The bus reset is the only input that clears the sequencer in the middle of a transaction.

Top module: `rd_xfer_seq`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `app_req`, `app_ready`, `bus_trdy`, `bus_stop`, `app_last`, `fifo_clr` and `wr_accept` are all 0.
- R2: In idle, `tgt_sel`=1 with `pend_other`=0 opens a transaction. From the next clock on, `app_req`=1 and `app_ready`=1, and the sequencer is in the hold phase.
- R3: In idle, `tgt_sel`=1 with `pend_other`=1 drives `bus_stop`=1 in that same cycle (retry). No transaction opens: `app_req` stays 0 in the next cycle.
- R4: In the hold phase, while `app_hold`=1 and `fifo_full`=0, `bus_trdy` stays 0 and the application may still write (`wr_accept` follows `app_den`).
- R5: In the hold phase, `app_hold`=0 or `fifo_full`=1 moves the sequencer to the data phase at the next clock. In the data phase `bus_trdy`=1 exactly while `fifo_empty`=0.
- R6: In the data phase, `fifo_empty`=1 gives `bus_stop`=1 and `bus_trdy`=0 in that cycle (disconnect), and the read ends. `mst_done`=1 also ends the read.
- R7: If the read ends with `app_den`=1, the sequencer enters the last phase. There `fifo_clr`=1, `app_last` equals `app_den`, and the sequencer stays in this phase until `app_den`=1 is seen.
- R8: If the read ends with `app_den`=0, then from the next clock `app_ready`=0 and `fifo_clr`=1, and `app_last` stays 0 for as long as `app_den`=0. Once `app_den`=1 is sampled, the last phase follows.
- R9: `wr_accept` is 1 only when `app_ready`=1, `app_den`=1 and `fifo_full`=0. Application writes are ignored while ready is low.
- R10: In the clock after the last-cycle indication, `app_req` falls and stays 0 for at least one clock. `tgt_sel` in that gap clock is ignored. A later selection opens a new transaction.
- R11: A bus reset in the middle of a transaction returns every output to the idle values of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Bus reset, asynchronous, active low |
| tgt_sel | input | 1 | Master has addressed this target for a read |
| pend_other | input | 1 | Another target transaction is pending, so answer with a retry |
| mst_done | input | 1 | Master is finishing its transfer |
| app_hold | input | 1 | Hold: postpone bus data phase while the FIFO prefills |
| app_den | input | 1 | Application data-enable |
| fifo_full | input | 1 | Target read FIFO is full |
| fifo_empty | input | 1 | Target read FIFO is empty |
| app_req | output | 1 | Transaction open towards the application |
| app_ready | output | 1 | Sequencer accepts application data |
| bus_trdy | output | 1 | Target data-ready on the bus |
| bus_stop | output | 1 | Target stop (disconnect or retry) |
| app_last | output | 1 | Master has taken its last needed word |
| fifo_clr | output | 1 | Flush the target read FIFO |
| wr_accept | output | 1 | Application write into the FIFO is taken |

## Verification
The block has no parameters, so the bench builds it as it stands. Its vector table walks two complete reads. The first prefills under hold until full, bursts, and ends with data-enable high. The second releases the hold, hits an empty FIFO, and waits on an idle application. Together these reach every state and both termination paths. Directed cases add the retry answer and a bus reset that lands in the middle of a read.

// File: rtl/rd_xfer_seq.sv
module rd_xfer_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic tgt_sel,
  input  logic pend_other,
  input  logic mst_done,
  input  logic app_hold,
  input  logic app_den,
  input  logic fifo_full,
  input  logic fifo_empty,
  output logic app_req,
  output logic app_ready,
  output logic bus_trdy,
  output logic bus_stop,
  output logic app_last,
  output logic fifo_clr,
  output logic wr_accept
);

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_HOLD = 3'd1,
    S_DATA = 3'd2,
    S_WAIT = 3'd3,
    S_LAST = 3'd4,
    S_GAP  = 3'd5
  } st_t;

  st_t state, nxt;
  logic in_data, ends;

  assign in_data = (state == S_DATA);
  assign ends    = in_data && (mst_done || fifo_empty);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: if (tgt_sel && !pend_other) nxt = S_HOLD;
      S_HOLD: if (!app_hold || fifo_full) nxt = S_DATA;
      S_DATA: if (ends) nxt = app_den ? S_LAST : S_WAIT;
      S_WAIT: if (app_den) nxt = S_LAST;
      S_LAST: if (app_den) nxt = S_GAP;
      S_GAP:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign app_req   = !(state == S_IDLE || state == S_GAP);
  assign app_ready = (state == S_HOLD) || in_data;
  assign bus_trdy  = in_data && !fifo_empty;
  assign bus_stop  = ((state == S_IDLE) && tgt_sel && pend_other) || (in_data && fifo_empty);
  assign app_last  = (state == S_LAST) && app_den;
  assign fifo_clr  = (state == S_WAIT) || (state == S_LAST);
  assign wr_accept = app_ready && app_den && !fifo_full;

endmodule

module rd_xfer_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state,
  input logic       tgt_sel,
  input logic       pend_other,
  input logic       mst_done,
  input logic       app_hold,
  input logic       app_den,
  input logic       fifo_full,
  input logic       fifo_empty,
  input logic       app_req,
  input logic       app_ready,
  input logic       bus_trdy,
  input logic       bus_stop,
  input logic       app_last,
  input logic       fifo_clr
);
  localparam logic [2:0] C_IDLE = 3'd0, C_HOLD = 3'd1, C_DATA = 3'd2,
                         C_WAIT = 3'd3, C_LAST = 3'd4;

  assert_retry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_IDLE && tgt_sel && pend_other) |=> !app_req);

  assert_hold_no_trdy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_HOLD && app_hold && !fifo_full) |-> !bus_trdy);

  assert_hold_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_HOLD && (!app_hold || fifo_full)) |=> (state == C_DATA));

  assert_empty_disc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_DATA && fifo_empty) |-> (bus_stop && !bus_trdy));

  assert_last_den_R7: assert property (@(posedge clk) disable iff (!rst_n)
    app_last |-> (app_den && fifo_clr));

  assert_idle_term_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_DATA && (mst_done || fifo_empty) && !app_den) |=> (!app_ready && fifo_clr));

  assert_wait_stay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_WAIT && !app_den) |=> (state == C_WAIT && !app_last));

  assert_req_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(app_req) |=> !app_req);

  assert_last_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == C_LAST && app_den) |=> !app_req);
endmodule

bind rd_xfer_seq rd_xfer_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .tgt_sel(tgt_sel),
  .pend_other(pend_other), .mst_done(mst_done), .app_hold(app_hold),
  .app_den(app_den), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
  .app_req(app_req), .app_ready(app_ready), .bus_trdy(bus_trdy),
  .bus_stop(bus_stop), .app_last(app_last), .fifo_clr(fifo_clr)
);

// File: tb/rd_xfer_seq_bench.sv
module rd_xfer_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tgt_sel = 0, pend_other = 0, mst_done = 0, app_hold = 0;
  logic app_den = 0, fifo_full = 0, fifo_empty = 0;
  logic app_req, app_ready, bus_trdy, bus_stop, app_last, fifo_clr, wr_accept;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rd_xfer_seq u_rd_xfer_seq (
    .clk(clk), .rst_n(rst_n), .tgt_sel(tgt_sel), .pend_other(pend_other),
    .mst_done(mst_done), .app_hold(app_hold), .app_den(app_den),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .app_req(app_req),
    .app_ready(app_ready), .bus_trdy(bus_trdy), .bus_stop(bus_stop),
    .app_last(app_last), .fifo_clr(fifo_clr), .wr_accept(wr_accept)
  );

  // {req tag[3:0], inputs sel,pend,done,hold,den,full,empty, outputs req,rdy,trdy,stop,last,clr,wacc}
  localparam logic [17:0] VEC [0:19] = '{
    {4'd3,  7'b1100000, 7'b0001000},  // R3 retry in idle
    {4'd3,  7'b0000000, 7'b0000000},  // R3 no transaction opened
    {4'd2,  7'b1000000, 7'b0000000},  // R2 select -> hold
    {4'd4,  7'b0001101, 7'b1100001},  // R4 hold, prefill accepted
    {4'd5,  7'b0001110, 7'b1100000},  // R5 full ends hold
    {4'd5,  7'b0001010, 7'b1110000},  // R5 data phase, trdy
    {4'd9,  7'b0000100, 7'b1110001},  // R9 write during burst
    {4'd7,  7'b0010100, 7'b1110001},  // R7 master done with den
    {4'd7,  7'b0000000, 7'b1000010},  // R7 last waits for den
    {4'd7,  7'b0000100, 7'b1000110},  // R7 last with den
    {4'd10, 7'b1000000, 7'b0000000},  // R10 gap ignores select
    {4'd10, 7'b1000000, 7'b0000000},  // R10 new select from idle
    {4'd5,  7'b0000000, 7'b1100000},  // R5 hold released
    {4'd6,  7'b0000001, 7'b1101000},  // R6 empty disconnect
    {4'd8,  7'b0000000, 7'b1000010},  // R8 ready low, flushing
    {4'd8,  7'b0000000, 7'b1000010},  // R8 still waiting
    {4'd9,  7'b0000100, 7'b1000010},  // R9 write ignored, R8 den seen
    {4'd7,  7'b0000100, 7'b1000110},  // R7 last after wait
    {4'd10, 7'b0000000, 7'b0000000},  // R10 gap
    {4'd10, 7'b0000000, 7'b0000000}   // R10 idle
  };

  task automatic drive(input logic [6:0] v);
    {tgt_sel, pend_other, mst_done, app_hold, app_den, fifo_full, fifo_empty} = v;
  endtask

  task automatic check(input int tag, input logic [6:0] exp, input int idx);
    logic [6:0] got;
    got = {app_req, app_ready, bus_trdy, bus_stop, app_last, fifo_clr, wr_accept};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL step %0d R%0d got %b exp %b", idx, tag, got, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    #2 check(1, 7'b0000000, -1);      // R1 during reset
    @(negedge clk);
    rst_n = 1'b1;
    #2 check(1, 7'b0000000, -2);      // R1 after reset
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      drive(VEC[i][13:7]);
      #2 check(int'(VEC[i][17:14]), VEC[i][6:0], i);
    end
    // R11: reset in the middle of a burst
    @(negedge clk); drive(7'b1000000);
    @(negedge clk); drive(7'b0000000);
    @(negedge clk); drive(7'b0000000);
    #2 check(11, 7'b1110000, 100);    // in data phase
    rst_n = 1'b0;
    #1 check(11, 7'b0000000, 101);    // R11 cleared
    @(negedge clk); rst_n = 1'b1;
    #2 check(11, 7'b0000000, 102);
    // R6 with master done and empty together, R8 then
    @(negedge clk); drive(7'b1000000);
    @(negedge clk); drive(7'b0000000);
    @(negedge clk); drive(7'b0010001);
    #2 check(6, 7'b1101000, 103);
    @(negedge clk); drive(7'b0000010);
    #2 check(8, 7'b1000010, 104);     // R8 ready low
    @(negedge clk); drive(7'b0000100);
    @(negedge clk); drive(7'b0000100);
    #2 check(7, 7'b1000110, 105);
    @(negedge clk); drive(7'b0000000);
    #2 check(10, 7'b0000000, 106);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule